// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Detection

This block receives asynchronous serial characters on one data line and turns them into parallel words for a processor. The line is sampled only on cycles where a receive-clock enable pulses, and that enable runs at one, sixteen or sixty-four times the bit rate, as chosen by a mode field. At the two higher rates a falling edge is taken as a possible start bit and is checked again half a bit later, so short glitches are rejected. Every later bit is sampled once per bit period, near its centre.

A finished character goes into a single holding register and raises a ready flag. Reading clears the flag. A new character that lands while the flag is still set replaces the old one and raises an overrun flag. Framing and parity problems raise their own flags. All three error flags stay set until an error-clear pulse is given. A separate output reports a break: the line has stayed low through the stop-bit positions of two characters in a row. It drops again as soon as the line is seen high.

Top module: `async_rx_brk`

## Requirements
- R1: After reset, rx_ready, err_overrun, err_frame, err_parity and brk_det are 0 and rx_data is all zeros.
- R2: baud_sel selects the factor F: 2'b00 gives 1, 2'b01 gives 16, 2'b10 and 2'b11 give 64. F is the number of rxc_tick pulses in one bit period. rxd is sampled only on rxc_tick cycles. Call the tick on which a low start is first seen t=0. The start bit is re-checked at t=F/2 (skipped for F=1). Each later bit is sampled at t=F/2+F*k for k=1,2,...
- R3: If the start re-check at t=F/2 finds rxd high, the frame is dropped: no character is stored and no flag changes.
- R4: The character length is 5+len_sel bits. Data arrives least significant bit first, is stored right-justified in rx_data, and the unused upper bits are 0.
- R5: rx_ready goes to 1 on the clock edge where the stop bit is sampled. One rd_strobe cycle clears it at the next edge, unless another character completes on that same edge.
- R6: If a character completes while rx_ready is already 1 and rd_strobe is low, err_overrun is set and rx_data takes the new character.
- R7: err_frame is set when the stop bit is sampled low. The character is still stored.
- R8: When par_en is 1, one parity bit follows the data bits. par_even=1 expects even parity over data and parity bit together; par_even=0 expects odd parity. err_parity is set on a mismatch.
- R9: err_overrun, err_frame and err_parity stay set until a one-cycle err_clr pulse. If a flag is set on the same edge as err_clr, it stays set.
- R10: brk_det goes to 1 when a stop bit is sampled low and the line has not been sampled high since an earlier stop bit that was also sampled low. It returns to 0 on the first rxc_tick that samples rxd high.
- R11: While rx_en is 0 the receiver stays idle, and no character is assembled or stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rxc_tick | input | 1 | Receive-clock enable, F pulses per bit |
| rxd | input | 1 | Serial data line, idle high, synchronous to clk |
| rx_en | input | 1 | Receiver enable |
| baud_sel | input | 2 | Oversampling factor select |
| len_sel | input | 2 | Character length minus five |
| par_en | input | 1 | Parity bit present and checked |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| err_clr | input | 1 | Clears the sticky error flags |
| rd_strobe | input | 1 | Processor read of the holding register |
| rx_data | output | 8 | Last received character |
| rx_ready | output | 1 | A character is waiting to be read |
| err_overrun | output | 1 | A character was overwritten before it was read |
| err_frame | output | 1 | A stop bit was sampled low |
| err_parity | output | 1 | A parity mismatch was found |
| brk_det | output | 1 | Break condition on the line |

## Verification
Some rules can be checked on every cycle, and assertions cover them. A read clears the ready flag. Overrun, framing and parity flags rise when a character completes under the matching condition. Error flags stay set until they are cleared. Break detection drops on the first high sample. A false start returns the receiver to idle. A disabled receiver stays idle. Other behaviour only shows over a whole frame, so the bench scenarios cover it: sampling points at each oversampling factor, bit order and right justification for the different lengths, even and odd parity outcomes, and break detection across two consecutive characters. The bench checks these with a tick-level reference model and with explicit checks at the end of each scenario.

// File: rtl/rxu_pkg.sv
package rxu_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } rx_state_e;

  // Last counter value of a full bit period for the selected factor.
  function automatic logic [5:0] full_last(input logic [1:0] sel);
    case (sel)
      2'b00:   full_last = 6'd0;
      2'b01:   full_last = 6'd15;
      default: full_last = 6'd63;
    endcase
  endfunction

  // Last counter value of half a bit period (start re-check point).
  function automatic logic [5:0] half_last(input logic [1:0] sel);
    case (sel)
      2'b01:   half_last = 6'd7;
      default: half_last = 6'd31;
    endcase
  endfunction

endpackage

// File: rtl/rxu_tick_ctr.sv
module rxu_tick_ctr #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic [CNT_W-1:0] full_last,
  input  logic [CNT_W-1:0] half_last,
  output logic             full_hit,
  output logic             half_hit
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign full_hit = tick && (cnt_q == full_last);
  assign half_hit = tick && (cnt_q == half_last);

endmodule

// File: rtl/rxu_frame_fsm.sv
module rxu_frame_fsm
  import rxu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              rx_en,
  input  logic              is_1x,
  input  logic [1:0]        len_sel,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              full_hit,
  input  logic              half_hit,
  output logic              ctr_clr,
  output logic              load,
  output logic              stop_bit,
  output logic              par_bad,
  output logic [DATA_W-1:0] char_out
);

  rx_state_e         state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] acc_q, acc_d;
  logic              pbit_q, pbit_d;
  logic [IDX_W-1:0]  last_idx;

  assign last_idx = IDX_W'(4) + IDX_W'(len_sel);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    acc_d   = acc_q;
    pbit_d  = pbit_q;
    ctr_clr = 1'b0;
    load    = 1'b0;
    if (!rx_en) begin
      state_d = ST_IDLE;
      ctr_clr = 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          ctr_clr = 1'b1;
          if (tick && !rxd) begin
            idx_d   = '0;
            acc_d   = '0;
            state_d = is_1x ? ST_DATA : ST_START;
          end
        end
        ST_START: begin
          if (half_hit) begin
            ctr_clr = 1'b1;
            state_d = rxd ? ST_IDLE : ST_DATA;
          end
        end
        ST_DATA: begin
          if (full_hit) begin
            ctr_clr       = 1'b1;
            acc_d[idx_q]  = rxd;
            idx_d         = idx_q + 1'b1;
            if (idx_q == last_idx) begin
              state_d = par_en ? ST_PAR : ST_STOP;
            end
          end
        end
        ST_PAR: begin
          if (full_hit) begin
            ctr_clr = 1'b1;
            pbit_d  = rxd;
            state_d = ST_STOP;
          end
        end
        ST_STOP: begin
          if (full_hit) begin
            ctr_clr = 1'b1;
            load    = 1'b1;
            state_d = ST_IDLE;
          end
        end
        default: begin
          state_d = ST_IDLE;
          ctr_clr = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      acc_q   <= '0;
      pbit_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      acc_q   <= acc_d;
      pbit_q  <= pbit_d;
    end
  end

  assign stop_bit = rxd;
  assign char_out = acc_q;
  assign par_bad  = par_en && (pbit_q != ((^acc_q) ^ ~par_even));

  // R11: a disabled receiver is idle on the following cycle
  p_disabled_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> state_q == ST_IDLE);

  // R3: a start re-check that sees the line high abandons the frame
  p_false_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && state_q == ST_START && half_hit && rxd) |=> state_q == ST_IDLE);

  // R2: at factor 1 a detected start goes straight to data sampling
  p_direct_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && is_1x && state_q == ST_IDLE && tick && !rxd) |=> state_q == ST_DATA);

endmodule

// File: rtl/rxu_hold_buf.sv
module rxu_hold_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              load,
  input  logic [DATA_W-1:0] char_in,
  input  logic              stop_bit,
  input  logic              par_bad,
  input  logic              rd_strobe,
  input  logic              err_clr,
  output logic [DATA_W-1:0] data_q,
  output logic              ready_q,
  output logic              ovr_q,
  output logic              frm_q,
  output logic              par_q,
  output logic              brk_q
);

  logic ready_d, ovr_d, frm_d, par_d, brk_d;
  logic armed_q, armed_d;
  logic hi_samp, low_stop;

  assign hi_samp  = tick && rxd;
  assign low_stop = load && !stop_bit;

  always_comb begin
    ready_d = load || (ready_q && !rd_strobe);
    ovr_d   = (load && ready_q && !rd_strobe) || (ovr_q && !err_clr);
    frm_d   = low_stop || (frm_q && !err_clr);
    par_d   = (load && par_bad) || (par_q && !err_clr);
    brk_d   = brk_q;
    armed_d = armed_q;
    if (hi_samp) begin
      brk_d   = 1'b0;
      armed_d = 1'b0;
    end else if (low_stop) begin
      brk_d   = armed_q || brk_q;
      armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (load) begin
      data_q <= char_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      ovr_q   <= 1'b0;
      frm_q   <= 1'b0;
      par_q   <= 1'b0;
      brk_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      ready_q <= ready_d;
      ovr_q   <= ovr_d;
      frm_q   <= frm_d;
      par_q   <= par_d;
      brk_q   <= brk_d;
      armed_q <= armed_d;
    end
  end

  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !load) |=> !ready_q);

  p_overrun_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && ready_q && !rd_strobe) |=> ovr_q);

  p_frame_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !stop_bit) |=> frm_q);

  p_parity_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && par_bad) |=> par_q);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovr_q || frm_q || par_q) && !err_clr) |=>
      ($past(ovr_q) -> ovr_q) && ($past(frm_q) -> frm_q) && ($past(par_q) -> par_q));

  p_break_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rxd) |=> !brk_q);

endmodule

// File: rtl/async_rx_brk.sv
module async_rx_brk
  import rxu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxc_tick,
  input  logic              rxd,
  input  logic              rx_en,
  input  logic [1:0]        baud_sel,
  input  logic [1:0]        len_sel,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              err_clr,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              err_overrun,
  output logic              err_frame,
  output logic              err_parity,
  output logic              brk_det
);

  logic [1:0]        rst_sync_q;
  logic              rst_ni;
  logic              ctr_clr, full_hit, half_hit;
  logic              load, stop_bit, par_bad;
  logic [DATA_W-1:0] char_w;
  logic [CNT_W-1:0]  full_lim, half_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_ni = rst_sync_q[1];

  assign full_lim = CNT_W'(full_last(baud_sel));
  assign half_lim = CNT_W'(half_last(baud_sel));

  rxu_tick_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_ni),
    .tick      (rxc_tick),
    .clr       (ctr_clr),
    .full_last (full_lim),
    .half_last (half_lim),
    .full_hit  (full_hit),
    .half_hit  (half_hit)
  );

  rxu_frame_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_ni),
    .tick     (rxc_tick),
    .rxd      (rxd),
    .rx_en    (rx_en),
    .is_1x    (baud_sel == 2'b00),
    .len_sel  (len_sel),
    .par_en   (par_en),
    .par_even (par_even),
    .full_hit (full_hit),
    .half_hit (half_hit),
    .ctr_clr  (ctr_clr),
    .load     (load),
    .stop_bit (stop_bit),
    .par_bad  (par_bad),
    .char_out (char_w)
  );

  rxu_hold_buf #(.DATA_W(DATA_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_ni),
    .tick      (rxc_tick),
    .rxd       (rxd),
    .load      (load),
    .char_in   (char_w),
    .stop_bit  (stop_bit),
    .par_bad   (par_bad),
    .rd_strobe (rd_strobe),
    .err_clr   (err_clr),
    .data_q    (rx_data),
    .ready_q   (rx_ready),
    .ovr_q     (err_overrun),
    .frm_q     (err_frame),
    .par_q     (err_parity),
    .brk_q     (brk_det)
  );

endmodule

// File: tb/async_rx_brk_bench.sv
module async_rx_brk_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxc_tick = 1'b0;
  logic       rxd = 1'b1;
  logic       rx_en = 1'b1;
  logic [1:0] baud_sel = 2'b01;
  logic [1:0] len_sel = 2'b11;
  logic       par_en = 1'b0;
  logic       par_even = 1'b1;
  logic       err_clr = 1'b0;
  logic       rd_strobe = 1'b0;
  logic [7:0] rx_data;
  logic       rx_ready, err_overrun, err_frame, err_parity, brk_det;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  async_rx_brk u_async_rx_brk (
    .clk(clk), .rst_n(rst_n), .rxc_tick(rxc_tick), .rxd(rxd), .rx_en(rx_en),
    .baud_sel(baud_sel), .len_sel(len_sel), .par_en(par_en), .par_even(par_even),
    .err_clr(err_clr), .rd_strobe(rd_strobe), .rx_data(rx_data), .rx_ready(rx_ready),
    .err_overrun(err_overrun), .err_frame(err_frame), .err_parity(err_parity),
    .brk_det(brk_det)
  );

  // receive-clock enable: one pulse every 4 clocks
  int tcnt = 0;
  always @(negedge clk) begin
    tcnt = (tcnt + 1) % 4;
    rxc_tick = (tcnt == 0);
  end

  // ---------------- tick-level reference model ----------------
  int rcnt = 0;
  bit m_active = 0;
  int m_t = 0;
  logic [7:0] m_acc = '0;
  logic m_pbit = 1'b0;
  logic [7:0] m_data = '0;
  bit m_ready = 0, m_ov = 0, m_fe = 0, m_pe = 0, m_brk = 0, m_armed = 0;

  always @(posedge clk) begin
    int f, h, l, j;
    bit ld, stop_low, pbad, ov_set;
    ld = 0; stop_low = 0; pbad = 0;
    f = (baud_sel == 2'b00) ? 1 : (baud_sel == 2'b01) ? 16 : 64;
    h = f / 2;
    l = 5 + int'(len_sel);
    if (!rst_n) rcnt = 0;
    if (!rst_n || rcnt < 2) begin
      if (rst_n) rcnt++;
      m_active = 0; m_t = 0; m_acc = '0; m_pbit = 0; m_data = '0;
      m_ready = 0; m_ov = 0; m_fe = 0; m_pe = 0; m_brk = 0; m_armed = 0;
    end else begin
      if (!rx_en) begin
        m_active = 0;
      end else if (rxc_tick) begin
        if (!m_active) begin
          if (!rxd) begin m_active = 1; m_t = 0; m_acc = '0; end
        end else begin
          m_t++;
          if (f > 1 && m_t == h) begin
            if (rxd) m_active = 0;
          end else if (m_t > h && (m_t - h) % f == 0) begin
            j = (m_t - h) / f;
            if (j <= l) m_acc[j-1] = rxd;
            else if (par_en && j == l + 1) m_pbit = rxd;
            else begin
              ld = 1; stop_low = !rxd; m_active = 0;
              pbad = par_en && (m_pbit != ((^m_acc) ^ !par_even));
            end
          end
        end
      end
      if (rxc_tick && rxd) begin m_brk = 0; m_armed = 0; end
      if (ld && stop_low) begin
        if (m_armed) m_brk = 1;
        m_armed = 1;
      end
      ov_set = ld && m_ready && !rd_strobe;
      m_ov = (m_ov && !err_clr) || ov_set;
      m_fe = (m_fe && !err_clr) || (ld && stop_low);
      m_pe = (m_pe && !err_clr) || (ld && pbad);
      if (ld) begin m_ready = 1; m_data = m_acc; end
      else if (rd_strobe) m_ready = 0;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && rcnt >= 2 && !done) begin
      check("R4 model rx_data", 32'(rx_data), 32'(m_data));
      check("R5 model rx_ready", 32'(rx_ready), 32'(m_ready));
      check("R6 model err_overrun", 32'(err_overrun), 32'(m_ov));
      check("R7 model err_frame", 32'(err_frame), 32'(m_fe));
      check("R8 model err_parity", 32'(err_parity), 32'(m_pe));
      check("R10 model brk_det", 32'(brk_det), 32'(m_brk));
    end
  end

  function automatic int factor();
    return (baud_sel == 2'b00) ? 1 : (baud_sel == 2'b01) ? 16 : 64;
  endfunction

  task automatic hold(input logic v, input int ticks);
    @(negedge clk) rxd = v;
    repeat (ticks * 4 - 1) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit bad_par, input logic stopv);
    int l;
    logic p;
    l = 5 + int'(len_sel);
    p = 1'b0;
    hold(1'b0, factor());
    for (int i = 0; i < l; i++) begin
      hold(d[i], factor());
      p = p ^ d[i];
    end
    if (par_en) hold((p ^ !par_even) ^ bad_par, factor());
    hold(stopv, factor());
    hold(1'b1, 2 * factor() + 2);
  endtask

  task automatic pulse_rd();
    @(negedge clk) rd_strobe = 1'b1;
    @(negedge clk) rd_strobe = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk) err_clr = 1'b1;
    @(negedge clk) err_clr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #1_500_000;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 rx_ready", 32'(rx_ready), 0);
    check("R1 rx_data", 32'(rx_data), 0);
    check("R1 flags", {28'd0, err_overrun, err_frame, err_parity, brk_det}, 0);

    // R2 R4 R5: 16x, 8 bits
    baud_sel = 2'b01; len_sel = 2'b11; par_en = 0;
    send(8'hA5, 0, 1'b1);
    check("R5 ready after char", 32'(rx_ready), 1);
    check("R4 data 8-bit", 32'(rx_data), 32'h A5);
    pulse_rd();
    check("R5 ready cleared by read", 32'(rx_ready), 0);

    // R2 R4: 1x, 5 bits
    baud_sel = 2'b00; len_sel = 2'b00;
    send(8'hF3, 0, 1'b1);
    check("R2 1x char ready", 32'(rx_ready), 1);
    check("R4 5-bit right justified", 32'(rx_data), 32'h13);
    pulse_rd();

    // R8: 64x, 7 bits, parity
    baud_sel = 2'b10; len_sel = 2'b10; par_en = 1; par_even = 1;
    send(8'h5A, 0, 1'b1);
    check("R4 7-bit data", 32'(rx_data), 32'h5A);
    check("R8 even parity good", 32'(err_parity), 0);
    pulse_rd();
    par_even = 0;
    send(8'h33, 0, 1'b1);
    check("R8 odd parity good", 32'(err_parity), 0);
    pulse_rd();
    send(8'h33, 1, 1'b1);
    check("R8 odd parity bad", 32'(err_parity), 1);
    pulse_rd();

    // R9: sticky across a good character, then cleared
    baud_sel = 2'b01; len_sel = 2'b11; par_en = 0;
    send(8'h11, 0, 1'b1);
    check("R9 parity flag sticky", 32'(err_parity), 1);
    pulse_rd();
    pulse_clr();
    check("R9 flag cleared", 32'(err_parity), 0);

    // R7: framing error, character still stored
    send(8'h6C, 0, 1'b0);
    check("R7 frame flag", 32'(err_frame), 1);
    check("R7 data stored", 32'(rx_data), 32'h6C);
    pulse_rd();
    pulse_clr();
    check("R9 frame cleared", 32'(err_frame), 0);

    // R6: overrun
    send(8'h01, 0, 1'b1);
    send(8'h02, 0, 1'b1);
    check("R6 overrun flag", 32'(err_overrun), 1);
    check("R6 newer data kept", 32'(rx_data), 32'h02);
    pulse_rd();
    pulse_clr();

    // R3: false start rejected
    hold(1'b0, 5);
    hold(1'b1, 60);
    check("R3 no char after glitch", 32'(rx_ready), 0);
    check("R3 data unchanged", 32'(rx_data), 32'h02);

    // R11: disabled receiver ignores a frame
    rx_en = 0;
    send(8'h7E, 0, 1'b1);
    check("R11 no char while disabled", 32'(rx_ready), 0);
    check("R11 data unchanged", 32'(rx_data), 32'h02);
    rx_en = 1;
    hold(1'b1, 4);

    // R10: break
    hold(1'b0, 500);
    check("R10 break detected", 32'(brk_det), 1);
    hold(1'b1, 3);
    check("R10 break cleared", 32'(brk_det), 0);
    pulse_rd();
    pulse_clr();
    repeat (10) @(negedge clk);
    finish_run();
  end

endmodule